// File: doc/BRIEF.md
# Driver Impedance Calibration Sequencer

This block steps a memory interface output driver through its impedance calibration without firmware. A start pulse launches a full run for one termination mode. The bench or the chip's analog front end supplies a one-bit comparator decision. The sequencer calibrates three legs one after another. First it trims the pull-up drive leg. Then it trims the pull-down drive leg and the pull-down termination leg, each against the pull-up setting already found. For each leg it presents a reference-voltage select code and enables the matching leg. It then walks a 5-bit strength code upward, one value per settle window, and samples the comparator at the end of each window.

The first code at which the comparator shows the leg's pass polarity becomes that leg's result. If the search reaches the top code without a pass, the result saturates and a per-leg failure flag is latched. Results are kept in two separate stores, one for termination off and one for termination on, so that a run in each mode leaves both sets available. The pull-up termination leg is never searched, and its field always reads zero.

Top module: `imp_cal_seq`

## Requirements
- R1: Each leg search starts at code 0 and raises the code by exactly one per step. Every code is held for SETTLE_CYC clock cycles and the comparator is sampled in the last of them. A run whose legs end at codes a, b and c therefore raises done_o SETTLE_CYC*(a+b+c+3) cycles after the edge that accepted start_i.
- R2: The pull-up drive leg passes when cmp_i is 1. Both pull-down legs pass when cmp_i is 0. A leg's result is the first code at which it passes.
- R3: A leg that has not passed by code 31 gets result 31 and its failure bit is set. fail_o bit 0 is the pull-up drive leg, bit 1 the pull-down drive leg and bit 2 the pull-down termination leg. The bits are cleared only when a new run is accepted.
- R4: Legs run in the order pull-up drive, pull-down drive, pull-down termination. The enables are (pu_en_o, pd_en_o) = (1,0), (0,0) and (0,1) respectively. The two enables are never both 1.
- R5: During the pull-up drive search, pu_code_o carries the searched code and pd_code_o is 0. During both pull-down searches, pu_code_o holds the pull-up result and pd_code_o carries the searched code.
- R6: vref_sel_o is 0x37, 0x33 and 0x37 for the three legs with odt_on_i = 0. It is 0x3A, 0x33 and 0x3A with odt_on_i = 1.
- R7: Results go to res_off_o or res_on_o according to the odt_on_i value captured at start. The 5-bit fields are: pull-up drive at bits 4:0, pull-down drive at 9:5, pull-up termination at 14:10 (always 0), and pull-down termination at 19:15. The store of the other mode is left unchanged.
- R8: A start_i pulse that arrives while a run is in progress has no effect. The run timing, the mode and the results stay those of the run already under way.
- R9: done_o is high for exactly one cycle, on the cycle after the pull-down termination search ends.
- R10: After reset both result stores and fail_o are 0. Whenever no run is in progress, both enables, both codes and vref_sel_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| odt_on_i | input | 1 | Termination mode for the run, captured at start |
| cmp_i | input | 1 | Comparator decision from the analog side |
| pu_code_o | output | 5 | Pull-up strength code |
| pd_code_o | output | 5 | Pull-down strength code |
| pu_en_o | output | 1 | Pull-up leg calibration enable |
| pd_en_o | output | 1 | Pull-down leg calibration enable |
| vref_sel_o | output | 6 | Reference voltage select code |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 3 | Latched per-leg saturation flags |
| res_off_o | output | 20 | Result store for termination off |
| res_on_o | output | 20 | Result store for termination on |

## Verification
The assertions assume that cmp_i is a settled, clean level whenever it is sampled. They also assume that start_i and odt_on_i are synchronous to clk. The bench's comparator model computes cmp_i combinationally from the enables and codes the block is driving, using one threshold per leg, so the level it presents is always the settled answer for the current code. Inputs change only on the falling edge. The thresholds are swept from 0 to 32, where 32 means the leg never passes, in both termination modes. The sweep includes runs in which a second start pulse arrives mid-run.

// File: rtl/imp_cal_pkg.sv
// Shared types for the impedance calibration sequencer.
// The enum value of each leg is also the index of its 5-bit result field.
package imp_cal_pkg;
    typedef enum logic [1:0] {
        LEG_PU_DRV  = 2'd0,
        LEG_PD_DRV  = 2'd1,
        LEG_PU_TERM = 2'd2,
        LEG_PD_TERM = 2'd3
    } leg_e;
    localparam int LEG_COUNT = 4;
    localparam int SEARCHED_LEGS = 3;
endpackage

// File: rtl/imp_settle_timer.sv
// Settle window timer.
// Assumes: load_i restarts a window of SETTLE_CYC cycles.
// expire_o is high in the last cycle of the window and stays high until the next load.
module imp_settle_timer #(
    parameter int SETTLE_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expire_o
);
    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Reload on request, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load_i)     cnt_q <= LOAD_VAL;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign expire_o = (cnt_q == '0);

    assert_timer_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD_VAL);
    assert_timer_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == LOAD_VAL));
endmodule

// File: rtl/imp_vref_lut.sv
// Reference voltage select lookup.
// Assumes: leg_i is a searched leg whenever active_i is high.
// The output is 0 when inactive.
module imp_vref_lut import imp_cal_pkg::*; #(
    parameter int VREF_W = 6,
    parameter logic [VREF_W-1:0] PU_OFF = 6'h37,
    parameter logic [VREF_W-1:0] PU_ON  = 6'h3A,
    parameter logic [VREF_W-1:0] PD_DRV = 6'h33,
    parameter logic [VREF_W-1:0] PD_OFF = 6'h37,
    parameter logic [VREF_W-1:0] PD_ON  = 6'h3A
) (
    input  logic              active_i,
    input  logic              odt_i,
    input  leg_e              leg_i,
    output logic [VREF_W-1:0] vref_o
);
    // Pick the code for the current leg and termination mode.
    always_comb begin
        vref_o = '0;
        if (active_i) begin
            unique case (leg_i)
                LEG_PU_DRV:  vref_o = odt_i ? PU_ON : PU_OFF;
                LEG_PD_DRV:  vref_o = PD_DRV;
                LEG_PD_TERM: vref_o = odt_i ? PD_ON : PD_OFF;
                default:     vref_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/imp_cal_seq.sv
// Impedance calibration sequencer (top).
// Runs a linear code search on the pull-up drive, pull-down drive and pull-down
// termination legs, in that order, and stores the results per termination mode.
// Assumes: cmp_i is settled by the end of each settle window.
// Assumes: start_i and odt_on_i are synchronous to clk.
module imp_cal_seq import imp_cal_pkg::*; #(
    parameter int SETTLE_CYC = 50,
    parameter int CODE_W     = 5,
    parameter int VREF_W     = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          odt_on_i,
    input  logic                          cmp_i,
    output logic [CODE_W-1:0]             pu_code_o,
    output logic [CODE_W-1:0]             pd_code_o,
    output logic                          pu_en_o,
    output logic                          pd_en_o,
    output logic [VREF_W-1:0]             vref_sel_o,
    output logic                          done_o,
    output logic [SEARCHED_LEGS-1:0]      fail_o,
    output logic [LEG_COUNT*CODE_W-1:0]   res_off_o,
    output logic [LEG_COUNT*CODE_W-1:0]   res_on_o
);
    localparam int RES_W = LEG_COUNT * CODE_W;
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic                     busy_q, mode_q, done_q;
    leg_e                     leg_q;
    logic [CODE_W-1:0]        code_q, pu_res_q;
    logic [SEARCHED_LEGS-1:0] fail_q;
    logic [RES_W-1:0]         res_off_q, res_on_q;
    logic                     expire, pass, hit, accept, tmr_load;
    int unsigned              fail_idx, field_base;

    // Pass polarity depends on the leg; a hit ends the leg's search.
    always_comb begin
        pass       = (leg_q == LEG_PU_DRV) ? cmp_i : !cmp_i;
        hit        = pass || (code_q == CODE_MAX);
        accept     = !busy_q && start_i;
        tmr_load   = accept || (busy_q && expire);
        fail_idx   = (leg_q == LEG_PD_TERM) ? 2 : int'(leg_q);
        field_base = int'(leg_q) * CODE_W;
    end

    imp_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .expire_o (expire)
    );

    imp_vref_lut #(.VREF_W(VREF_W)) u_vref (
        .active_i (busy_q),
        .odt_i    (mode_q),
        .leg_i    (leg_q),
        .vref_o   (vref_sel_o)
    );

    // Sequencer: start capture, code stepping, leg advance and result storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            mode_q    <= 1'b0;
            done_q    <= 1'b0;
            leg_q     <= LEG_PU_DRV;
            code_q    <= '0;
            pu_res_q  <= '0;
            fail_q    <= '0;
            res_off_q <= '0;
            res_on_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q   <= 1'b1;
                mode_q   <= odt_on_i;
                leg_q    <= LEG_PU_DRV;
                code_q   <= '0;
                pu_res_q <= '0;
                fail_q   <= '0;
            end else if (busy_q && expire) begin
                if (hit) begin
                    if (mode_q) res_on_q[field_base +: CODE_W]  <= code_q;
                    else        res_off_q[field_base +: CODE_W] <= code_q;
                    fail_q[fail_idx] <= !pass;
                    code_q <= '0;
                    unique case (leg_q)
                        LEG_PU_DRV: begin
                            pu_res_q <= code_q;
                            leg_q    <= LEG_PD_DRV;
                        end
                        LEG_PD_DRV: leg_q <= LEG_PD_TERM;
                        default: begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                            leg_q  <= LEG_PU_DRV;
                        end
                    endcase
                end else begin
                    code_q <= code_q + 1'b1;
                end
            end
        end
    end

    // Drive the analog controls from the current leg; everything is 0 when idle.
    always_comb begin
        pu_en_o   = busy_q && (leg_q == LEG_PU_DRV);
        pd_en_o   = busy_q && (leg_q == LEG_PD_TERM);
        pu_code_o = !busy_q ? '0 : ((leg_q == LEG_PU_DRV) ? code_q : pu_res_q);
        pd_code_o = (busy_q && (leg_q != LEG_PU_DRV)) ? code_q : '0;
    end

    assign done_o    = done_q;
    assign fail_o    = fail_q;
    assign res_off_o = res_off_q;
    assign res_on_o  = res_on_q;

    assert_code_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && leg_q == $past(leg_q) && code_q != $past(code_q))
        |-> code_q == $past(code_q) + 1'b1);
    assert_enables_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(pu_en_o && pd_en_o));
    assert_pu_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && leg_q != LEG_PU_DRV) |-> (pu_code_o == res_off_o[CODE_W-1:0] && !mode_q)
                                         || (pu_code_o == res_on_o[CODE_W-1:0] && mode_q));
    assert_term_field_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_off_o[2*CODE_W +: CODE_W] == '0 && res_on_o[2*CODE_W +: CODE_W] == '0);
    assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_i && !expire) |=> $stable(mode_q) && $stable(leg_q));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (!pu_en_o && !pd_en_o && pu_code_o == '0 && pd_code_o == '0
                     && vref_sel_o == '0));
endmodule

// File: tb/imp_cal_seq_bench.sv
module imp_cal_seq_bench;
    localparam int S = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic odt_on_i = 1'b0;
    logic cmp_i;
    logic [4:0] pu_code_o, pd_code_o;
    logic pu_en_o, pd_en_o, done_o;
    logic [5:0] vref_sel_o;
    logic [2:0] fail_o;
    logic [19:0] res_off_o, res_on_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int th_pu = 0, th_pd = 0, th_tm = 0;
    logic [19:0] exp_off = '0, exp_on = '0;

    always #10 clk = ~clk;

    imp_cal_seq #(.SETTLE_CYC(S)) u_imp_cal_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .odt_on_i(odt_on_i), .cmp_i(cmp_i),
        .pu_code_o(pu_code_o), .pd_code_o(pd_code_o), .pu_en_o(pu_en_o), .pd_en_o(pd_en_o),
        .vref_sel_o(vref_sel_o), .done_o(done_o), .fail_o(fail_o),
        .res_off_o(res_off_o), .res_on_o(res_on_o)
    );

    // Comparator model: one threshold per leg; 32 means the leg never passes.
    always_comb begin
        if (pu_en_o)      cmp_i = (int'(pu_code_o) >= th_pu);
        else if (pd_en_o) cmp_i = !(int'(pd_code_o) >= th_tm);
        else              cmp_i = !(int'(pd_code_o) >= th_pd);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic int sat(input int t);
        return (t < 32) ? t : 31;
    endfunction

    task automatic run_cal(input bit odt, input int tp, input int tn, input int tt, input bit inject);
        int rp = sat(tp), rn = sat(tn), rt = sat(tt);
        int exp_cyc = S * (rp + rn + rt + 3);
        int cnt = 0, stage = 0, mon_bad = 0, leg;
        logic [19:0] other_before = odt ? res_off_o : res_on_o;
        logic [19:0] exp_res = {5'(rt), 5'd0, 5'(rn), 5'(rp)};
        logic [2:0] exp_fail = {tt >= 32, tn >= 32, tp >= 32};
        logic [5:0] v_outer = odt ? 6'h3A : 6'h37;
        th_pu = tp; th_pd = tn; th_tm = tt;
        @(negedge clk); start_i = 1'b1; odt_on_i = odt;
        @(posedge clk);
        @(negedge clk); start_i = 1'b0;
        while (!done_o && cnt < 5000) begin
            if (inject && cnt == 5) begin start_i = 1'b1; odt_on_i = !odt; end
            if (inject && cnt == 6) start_i = 1'b0;
            // Leg monitor for order, enables, code holding and vref (R4, R5, R6)
            if (pu_en_o && pd_en_o) leg = -1;
            else if (pu_en_o) leg = 0;
            else if (pd_en_o) leg = 2;
            else leg = 1;
            if (leg < stage || leg > stage + 1) mon_bad++;
            else stage = leg;
            case (leg)
                0: if (pd_code_o != 0 || vref_sel_o != v_outer) mon_bad++;
                1: if (pu_code_o != 5'(rp) || vref_sel_o != 6'h33) mon_bad++;
                2: if (pu_code_o != 5'(rp) || vref_sel_o != v_outer) mon_bad++;
                default: mon_bad++;
            endcase
            @(negedge clk); cnt++;
        end
        if (odt) exp_on = exp_res; else exp_off = exp_res;
        check(cnt == exp_cyc, inject ? "R8 run timing with extra start" : "R1 done timing", cnt, exp_cyc);
        check(mon_bad == 0 && stage == 2, "R4/R5/R6 leg controls", mon_bad, 0);
        check((odt ? res_on_o : res_off_o) == exp_res, "R2/R3 results", odt ? res_on_o : res_off_o, exp_res);
        check((odt ? res_off_o : res_on_o) == other_before, "R7 other mode store", odt ? res_off_o : res_on_o, other_before);
        check(fail_o == exp_fail, "R3 fail flags", fail_o, exp_fail);
        @(negedge clk);
        check(done_o == 1'b0, "R9 done single cycle", done_o, 0);
        repeat (3) @(negedge clk);
        check({pu_en_o, pd_en_o, pu_code_o, pd_code_o, vref_sel_o} == '0, "R10 idle outputs", pu_code_o, 0);
        check(fail_o == exp_fail, "R3 fail flags held", fail_o, exp_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_off_o == '0 && res_on_o == '0, "R10 reset stores", res_off_o, 0);
        check(fail_o == '0 && done_o == 1'b0, "R10 reset flags", fail_o, 0);
        check({pu_en_o, pd_en_o, pu_code_o, pd_code_o, vref_sel_o} == '0, "R10 reset outputs", pu_code_o, 0);
        for (int k = 0; k < 33; k++)
            run_cal(k[0], k, (k * 7 + 3) % 33, (k * 13 + 5) % 33, 1'b0);
        run_cal(1'b0, 32, 32, 32, 1'b0);
        run_cal(1'b1, 0, 0, 0, 1'b0);
        run_cal(1'b0, 9, 4, 20, 1'b1);
        run_cal(1'b1, 31, 17, 2, 1'b1);
        check(res_off_o == exp_off && res_on_o == exp_on, "R7 final stores", res_off_o, exp_off);
        summary();
    end
endmodule